// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns an effective offset into a linear address using one entry of a segment descriptor cache: the base, the limit and a few type bits. In the same cycle it decides whether the access breaks the segment limit or the segment's permissions. The address and the violation flag come out of one output register, one clock after the request.

A violation never holds back the address. The address is always produced, and the flag travels with it so that the pipeline behind can raise an exception later.

In legacy protected operation, the low 32 bits of the base and of the offset are added, and the result wraps modulo 2^32. In 64-bit operation, ordinary segments pass the full offset through unchanged and have no limit check. A segment marked as one of the two extra segments instead adds a full 64-bit base, which comes from a separate base input.

Top module: `seg_lin_addr_gen`

## Requirements
- R1: While reset is held, `lin_vld`, `viol` and `lin_addr` are zero. A request accepted on a clock edge shows `lin_vld` high one cycle later, with its address and flag.
- R2: When `long_mode` is 0, `lin_addr` = (`seg_base[31:0]` + `offset[31:0]`) mod 2^32, and bits 63:32 are zero. `seg_base[63:32]`, `offset[63:32]`, `seg_ext_en` and `ext_base` have no effect.
- R3: When `long_mode` is 0, an access of `len_m1`+1 bytes is a violation if `offset[31:0]` + `len_m1` > `seg_limit`. This sum is formed without wrapping, so an offset of 0xFFFFFFFF with `len_m1`=1 is a violation even when the limit is 0xFFFFFFFF.
- R4: When `long_mode` is 1 and `seg_ext_en` is 0, `lin_addr` equals the full 64-bit `offset`. No limit check is made.
- R5: When `long_mode` is 1 and `seg_ext_en` is 1, `lin_addr` = (`ext_base` + `offset`) mod 2^64. No limit check is made.
- R6: A write (`acc_kind`=2'b01) is a violation if `seg_is_code` is 1 or `seg_wr_ok` is 0. This holds in both modes.
- R7: An execute (`acc_kind`=2'b10) is a violation on a data segment (`seg_is_code`=0). A read (`acc_kind`=2'b00 or 2'b11) is a violation on a code segment whose `seg_rd_ok` is 0. This holds in both modes.
- R8: A violating access still delivers its full computed address, with `lin_vld` high.
- R9: A cycle with `req_vld` low gives `lin_vld`=0 and `viol`=0 in the next cycle, and `lin_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| offset | input | 64 | Effective offset |
| len_m1 | input | 3 | Access length in bytes minus one |
| acc_kind | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| long_mode | input | 1 | 1 selects 64-bit operation |
| seg_ext_en | input | 1 | Segment is one of the two extra segments with a 64-bit base |
| ext_base | input | 64 | 64-bit base for an extra segment |
| seg_base | input | 64 | Base from the descriptor cache |
| seg_limit | input | 32 | Byte-granular limit from the descriptor cache |
| seg_is_code | input | 1 | Segment is a code segment |
| seg_wr_ok | input | 1 | Data segment allows writes |
| seg_rd_ok | input | 1 | Code segment allows reads |
| lin_addr | output | 64 | Registered linear address |
| lin_vld | output | 1 | Registered request valid |
| viol | output | 1 | Registered limit or permission violation |

## Verification
The hardest case to reach is a multi-byte access at the very top of the 32-bit offset space. There the end-of-access sum would wrap if it were formed in 32 bits, and random offsets almost never land in that last window. Directed steps therefore place offsets at 0xFFFFFFFF and just below a chosen limit, with several lengths. A reference model then compares every cycle, including idle cycles whose inputs hold garbage, so that an address that fails to hold is caught.

// File: rtl/seg_lin_addr_gen.sv
module seg_lin_addr_gen #(
  parameter int AW  = 64,
  parameter int PW  = 32,
  parameter int SZW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [AW-1:0] offset,
  input  logic [SZW-1:0] len_m1,
  input  logic [1:0]    acc_kind,
  input  logic          long_mode,
  input  logic          seg_ext_en,
  input  logic [AW-1:0] ext_base,
  input  logic [AW-1:0] seg_base,
  input  logic [PW-1:0] seg_limit,
  input  logic          seg_is_code,
  input  logic          seg_wr_ok,
  input  logic          seg_rd_ok,
  output logic [AW-1:0] lin_addr,
  output logic          lin_vld,
  output logic          viol
);
  localparam logic [1:0] K_WR = 2'b01;
  localparam logic [1:0] K_EX = 2'b10;

  logic [PW-1:0] pm_sum;
  logic [AW-1:0] lm_sum;
  logic [AW-1:0] nxt_addr;
  logic [PW:0]   last_byte;
  logic          is_wr, is_ex, is_rd;
  logic          lim_bad, perm_bad;

  assign pm_sum    = seg_base[PW-1:0] + offset[PW-1:0];
  assign lm_sum    = (seg_ext_en ? ext_base : '0) + offset;
  assign nxt_addr  = long_mode ? lm_sum : {{(AW-PW){1'b0}}, pm_sum};

  assign last_byte = {1'b0, offset[PW-1:0]} + {{(PW+1-SZW){1'b0}}, len_m1};
  assign lim_bad   = !long_mode && (last_byte > {1'b0, seg_limit});

  assign is_wr     = (acc_kind == K_WR);
  assign is_ex     = (acc_kind == K_EX);
  assign is_rd     = !is_wr && !is_ex;
  assign perm_bad  = (is_wr && (seg_is_code || !seg_wr_ok)) ||
                     (is_ex && !seg_is_code) ||
                     (is_rd && seg_is_code && !seg_rd_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_addr <= '0;
      lin_vld  <= 1'b0;
      viol     <= 1'b0;
    end else begin
      lin_vld <= req_vld;
      viol    <= req_vld && (lim_bad || perm_bad);
      if (req_vld) lin_addr <= nxt_addr;
    end
  end
endmodule

module seg_lin_addr_gen_chk #(
  parameter int AW  = 64,
  parameter int PW  = 32,
  parameter int SZW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [AW-1:0] offset,
  input logic [SZW-1:0] len_m1,
  input logic [1:0]    acc_kind,
  input logic          long_mode,
  input logic          seg_ext_en,
  input logic [AW-1:0] ext_base,
  input logic [AW-1:0] seg_base,
  input logic [PW-1:0] seg_limit,
  input logic          seg_is_code,
  input logic          seg_wr_ok,
  input logic          seg_rd_ok,
  input logic [AW-1:0] lin_addr,
  input logic          lin_vld,
  input logic          viol
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> lin_vld); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!lin_vld && !viol && $stable(lin_addr))); // R9
  AST_PM_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !long_mode) |=> (lin_addr[AW-1:PW] == '0)); // R2
  AST_PM_TOP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !long_mode && (offset[PW-1:0] == '1) && (len_m1 != '0)) |=> viol); // R3
  AST_LM_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && long_mode && !seg_ext_en) |=> (lin_addr == $past(offset))); // R4
  AST_LM_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && long_mode && !seg_is_code && (acc_kind == 2'b00)) |=> !viol); // R4
  AST_WR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (acc_kind == 2'b01) && seg_is_code) |=> viol); // R6
  AST_EX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (acc_kind == 2'b10) && !seg_is_code) |=> viol); // R7
  AST_VIOL_HAS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> lin_vld); // R8
endmodule

bind seg_lin_addr_gen seg_lin_addr_gen_chk #(.AW(AW), .PW(PW), .SZW(SZW)) u_chk (.*);

// File: tb/test_seg_lin_addr_gen.sv
module test_seg_lin_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [63:0] offset;
  logic [2:0]  len_m1;
  logic [1:0]  acc_kind;
  logic        long_mode, seg_ext_en;
  logic [63:0] ext_base, seg_base;
  logic [31:0] seg_limit;
  logic        seg_is_code, seg_wr_ok, seg_rd_ok;
  logic [63:0] lin_addr;
  logic        lin_vld, viol;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [63:0] exp_addr = '0;

  seg_lin_addr_gen i_seg_lin_addr_gen (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, expv);
    end
  endtask

  function automatic void model(input logic [63:0] off, input logic [2:0] lm1,
                                input logic [1:0] k, input logic lm, input logic xe,
                                input logic [63:0] xb, input logic [63:0] b,
                                input logic [31:0] lim, input logic c, input logic w,
                                input logic r, output logic [63:0] a, output logic bad);
    longint unsigned s;
    bit lb, pb;
    if (lm) begin
      s  = (xe ? longint'(xb) : 64'd0) + longint'(off);
      lb = 0;
    end else begin
      s  = (longint'(b[31:0]) + longint'(off[31:0])) & 64'h0000_0000_FFFF_FFFF;
      lb = (longint'(off[31:0]) + longint'(lm1)) > longint'(lim);
    end
    case (k)
      2'b01:   pb = c || !w;
      2'b10:   pb = !c;
      default: pb = c && !r;
    endcase
    a   = s;
    bad = lb || pb;
  endfunction

  task automatic step(string tag, logic v, logic [63:0] off, logic [2:0] lm1,
                      logic [1:0] k, logic lm, logic xe, logic [63:0] xb,
                      logic [63:0] b, logic [31:0] lim, logic c, logic w, logic r);
    logic [63:0] a;
    logic bad;
    @(negedge clk);
    req_vld = v; offset = off; len_m1 = lm1; acc_kind = k; long_mode = lm;
    seg_ext_en = xe; ext_base = xb; seg_base = b; seg_limit = lim;
    seg_is_code = c; seg_wr_ok = w; seg_rd_ok = r;
    model(off, lm1, k, lm, xe, xb, b, lim, c, w, r, a, bad);
    if (v) exp_addr = a;
    @(posedge clk);
    #1;
    chk(tag, "lin_vld", {63'd0, lin_vld}, {63'd0, v});
    chk(tag, "lin_addr", lin_addr, exp_addr);
    chk(tag, "viol", {63'd0, viol}, {63'd0, v && bad});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; offset = '0; len_m1 = '0; acc_kind = '0;
    long_mode = 1'b0; seg_ext_en = 1'b0; ext_base = '0; seg_base = '0;
    seg_limit = '0; seg_is_code = 1'b0; seg_wr_ok = 1'b0; seg_rd_ok = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset lin_vld", {63'd0, lin_vld}, 64'd0);
    chk("R1", "reset viol", {63'd0, viol}, 64'd0);
    chk("R1", "reset lin_addr", lin_addr, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 plain add, then 32-bit wrap with upper bits and extra base ignored
    step("R2", 1, 64'h20, 0, 2'b00, 0, 0, 0, 64'h1000, 32'hFFFF, 0, 1, 0);
    step("R2", 1, 64'hDEAD_0000_0000_0020, 0, 2'b00, 0, 1, 64'h5555, 64'hABCD_0000_FFFF_FFF0,
         32'hFFFF_FFFF, 0, 1, 0);
    // R3 limit edge: last byte on limit passes, one beyond fails (R8 address kept)
    step("R3", 1, 64'hFC, 3, 2'b00, 0, 0, 0, 64'h0, 32'hFF, 0, 1, 0);
    step("R8", 1, 64'hFD, 3, 2'b00, 0, 0, 0, 64'h4000, 32'hFF, 0, 1, 0);
    // R3 top of offset range must not wrap
    step("R3", 1, 64'hFFFF_FFFF, 1, 2'b00, 0, 0, 0, 64'h0, 32'hFFFF_FFFF, 0, 1, 0);
    step("R3", 1, 64'hFFFF_FFFF, 0, 2'b00, 0, 0, 0, 64'h0, 32'hFFFF_FFFF, 0, 1, 0);
    step("R3", 1, 64'hFFFF_FFFA, 7, 2'b00, 0, 0, 0, 64'h10, 32'hFFFF_FFFF, 0, 1, 0);
    // R4 long mode flat, limit ignored
    step("R4", 1, 64'h1234_5678_9ABC_DEF0, 7, 2'b00, 1, 0, 64'h77, 64'h9999, 32'h0, 0, 1, 0);
    // R5 extra segment base, 64-bit wrap
    step("R5", 1, 64'h200, 0, 2'b00, 1, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 32'h0, 0, 1, 0);
    // R6 writes
    step("R6", 1, 64'h10, 0, 2'b01, 0, 0, 0, 64'h0, 32'hFFFF, 1, 1, 1);
    step("R6", 1, 64'h10, 0, 2'b01, 1, 0, 0, 64'h0, 32'hFFFF, 0, 0, 0);
    step("R6", 1, 64'h10, 0, 2'b01, 0, 0, 0, 64'h0, 32'hFFFF, 0, 1, 0);
    // R7 execute and read of code
    step("R7", 1, 64'h10, 0, 2'b10, 0, 0, 0, 64'h0, 32'hFFFF, 0, 1, 1);
    step("R7", 1, 64'h10, 0, 2'b00, 0, 0, 0, 64'h0, 32'hFFFF, 1, 0, 0);
    step("R7", 1, 64'h10, 0, 2'b11, 1, 0, 0, 64'h0, 32'hFFFF, 1, 0, 1);
    step("R7", 1, 64'h10, 0, 2'b10, 1, 0, 0, 64'h0, 32'hFFFF, 1, 0, 0);
    // R9 idle with garbage inputs
    step("R9", 0, 64'hFFFF_FFFF_FFFF_FFFF, 7, 2'b01, 0, 1, 64'h1, 64'h2, 32'h0, 1, 0, 0);
    step("R9", 0, 64'h0, 0, 2'b10, 1, 0, 64'h3, 64'h4, 32'h0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      logic lm, xe, v;
      logic [63:0] off;
      string tag;
      lm  = $urandom_range(0, 1);
      xe  = $urandom_range(0, 1);
      v   = ($urandom_range(0, 7) != 0);
      off = {$urandom, $urandom};
      if (!lm && $urandom_range(0, 3) == 0) off[31:0] = 32'hFFFF_FFFF - $urandom_range(0, 8);
      tag = !v ? "R9" : (lm ? (xe ? "R5" : "R4") : "R3");
      step(tag, v, off, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), lm, xe,
           {$urandom, $urandom}, {$urandom, $urandom},
           ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF : $urandom,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule